// File: doc/BRIEF.md
# Paired-Clock Multichannel PWM Controller

This block is a PWM peripheral with a parameterized number of channels. Software programs it through a simple synchronous register bus, and each channel drives a waveform pin together with an output-enable. The channels are grouped in pairs. Both channels of a pair share one clock-source choice and one power-of-two divider.

The two clock sources arrive as single-cycle enable strobes in the block's only clock domain: an oscillator strobe and a bus-clock strobe. Each channel adds its own 8-bit prescaler to the shared divided pulse. It then counts ticks through a programmable period, and its output is active for a programmable number of ticks at the start of each period.

A write to a channel's control or period register takes effect at once, without waiting for the current period to finish. A channel whose enable bit is clear releases its pin by dropping its output-enable.

Top module: `pairpwm`

## Requirements
- R1: After reset every register reads back zero and every `pwm_oe` bit is low.
- R2: Register readback uses these word addresses. Pair p config sits at 0x20+4p and holds bits [8:7] (source) and [3:0] (div_m). Channel c control sits at 0x100+0x20c and holds bits [8:0]. Channel c period sits at 0x104+0x20c and holds all 32 bits. The gate register sits at 0x40, with bit c as the gate and bit c+16 as the bypass. The enable register sits at 0x80, with bit c as the enable. Every other bit reads zero.
- R3: An address that is unmapped, misaligned, or that names a channel or pair beyond NUM_CH reads zero, and a write to it changes no register.
- R4: `pwm_oe[c]` equals enable bit c, and `pwm_out[c]` is low while that bit is clear.
- R5: The period field (period bits [31:16]) holds N−1 for an N-tick period. The output is active during the first A ticks of each period, where A is period bits [15:0]. Control bit 8 set makes the active level high; clear makes it low.
- R6: An active count larger than the period field acts as if it equalled that field.
- R7: The channel counter advances once every (k+1) divided pulses, where k is control bits [7:0].
- R8: The pair divider emits one pulse per 2^m selected source strobes. Here m is config bits [3:0], and a value above 8 acts as 8.
- R9: Config source bits [8:7] equal to zero select the oscillator strobe. Any nonzero value selects the bus strobe. Both channels of a pair use that pair's selection.
- R10: A channel counts only while both its enable bit and its gate bit are set. Otherwise its counter is held at tick 0 of the period.
- R11: While a channel's bypass bit and enable bit are set, its output follows the divided pair pulse.
- R12: A period write takes effect mid-period. If the new period field is below the current tick, the count restarts at tick 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator clock-enable strobe |
| bus_tick | input | 1 | Bus-clock clock-enable strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pwm_out | output | NUM_CH | Per-channel waveform |
| pwm_oe | output | NUM_CH | Per-channel output-enable; low means high-impedance |

## Verification
The bench builds the block with NUM_CH=3, so the second pair has only one channel. The fourth channel's and third pair's addresses then fall out of range, which exercises the bounds decode. DIV_MAX keeps its default of 8, so a div_m of 12 produces 256-strobe pulses that the bench can measure in about a thousand cycles. Duty is measured by counting high cycles over a window that is a whole number of periods. This makes the results independent of the counter's phase.

// File: rtl/pairpwm_pkg.sv
package pairpwm_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned PRESC_W = 8;
   localparam int unsigned CNT_W   = 16;
   localparam int unsigned DIVF_W  = 4;
   localparam int unsigned SRC_W   = 2;
   localparam int unsigned BYP_OFS = 16;

   localparam logic [11:0] PAIR_BASE = 12'h020;
   localparam logic [11:0] GATE_ADDR = 12'h040;
   localparam logic [11:0] ENA_ADDR  = 12'h080;
   localparam logic [11:0] CH_BASE   = 12'h100;
   localparam int unsigned CH_STRIDE = 32;
   localparam int unsigned PAIR_STEP = 4;
   localparam int unsigned PER_OFS   = 4;

   typedef struct packed {
      logic [SRC_W-1:0]  src;
      logic [DIVF_W-1:0] div_m;
   } pair_cfg_t;

   typedef struct packed {
      logic               pol;
      logic [PRESC_W-1:0] presc;
      logic [CNT_W-1:0]   ent;
      logic [CNT_W-1:0]   act;
   } chan_cfg_t;
endpackage

// File: rtl/pairpwm_regs.sv
module pairpwm_regs
   import pairpwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned NPAIR  = 2,
   parameter int unsigned ADDR_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic                    reg_we,
   input  logic [BUS_W-1:0]        reg_wdata,
   output logic [BUS_W-1:0]        reg_rdata,
   output pair_cfg_t [NPAIR-1:0]   pair_q,
   output chan_cfg_t [NUM_CH-1:0]  chan_q,
   output logic [NUM_CH-1:0]       en_q,
   output logic [NUM_CH-1:0]       gate_q,
   output logic [NUM_CH-1:0]       byp_q
);

   function automatic logic [ADDR_W-1:0] pair_addr(input int p);
      return ADDR_W'(PAIR_BASE) + ADDR_W'(p * PAIR_STEP);
   endfunction

   function automatic logic [ADDR_W-1:0] ctl_addr(input int c);
      return ADDR_W'(CH_BASE) + ADDR_W'(c * CH_STRIDE);
   endfunction

   function automatic logic [ADDR_W-1:0] per_addr(input int c);
      return ADDR_W'(CH_BASE) + ADDR_W'(c * CH_STRIDE + PER_OFS);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pair_q <= '0;
         chan_q <= '0;
         en_q   <= '0;
         gate_q <= '0;
         byp_q  <= '0;
      end else if (reg_we) begin
         if (reg_addr == ADDR_W'(GATE_ADDR)) begin
            for (int i = 0; i < NUM_CH; i++) begin
               gate_q[i] <= reg_wdata[i];
               byp_q[i]  <= reg_wdata[BYP_OFS+i];
            end
         end
         if (reg_addr == ADDR_W'(ENA_ADDR)) begin
            en_q <= reg_wdata[NUM_CH-1:0];
         end
         for (int p = 0; p < NPAIR; p++) begin
            if (reg_addr == pair_addr(p)) begin
               pair_q[p].src   <= reg_wdata[8:7];
               pair_q[p].div_m <= reg_wdata[DIVF_W-1:0];
            end
         end
         for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ctl_addr(c)) begin
               chan_q[c].pol   <= reg_wdata[PRESC_W];
               chan_q[c].presc <= reg_wdata[PRESC_W-1:0];
            end
            if (reg_addr == per_addr(c)) begin
               chan_q[c].ent <= reg_wdata[BUS_W-1:CNT_W];
               chan_q[c].act <= reg_wdata[CNT_W-1:0];
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(GATE_ADDR)) begin
         for (int i = 0; i < NUM_CH; i++) begin
            reg_rdata[i]         = gate_q[i];
            reg_rdata[BYP_OFS+i] = byp_q[i];
         end
      end
      if (reg_addr == ADDR_W'(ENA_ADDR)) begin
         reg_rdata[NUM_CH-1:0] = en_q;
      end
      for (int p = 0; p < NPAIR; p++) begin
         if (reg_addr == pair_addr(p)) begin
            reg_rdata[8:7]        = pair_q[p].src;
            reg_rdata[DIVF_W-1:0] = pair_q[p].div_m;
         end
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (reg_addr == ctl_addr(c)) begin
            reg_rdata[PRESC_W]     = chan_q[c].pol;
            reg_rdata[PRESC_W-1:0] = chan_q[c].presc;
         end
         if (reg_addr == per_addr(c)) begin
            reg_rdata = {chan_q[c].ent, chan_q[c].act};
         end
      end
   end

endmodule

// File: rtl/pairpwm_pairdiv.sv
module pairpwm_pairdiv
   import pairpwm_pkg::*;
#(
   parameter int unsigned DIV_MAX = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      osc_tick,
   input  logic      bus_tick,
   input  pair_cfg_t cfg,
   output logic      tick
);

   logic strobe;
   assign strobe = (cfg.src == '0) ? osc_tick : bus_tick;

   if (DIV_MAX == 0) begin : g_nodiv
      logic unused_div;
      assign unused_div = ^cfg.div_m;
      always_ff @(posedge clk) begin
         if (!rst_n) tick <= 1'b0;
         else        tick <= strobe;
      end
   end else begin : g_div
      localparam int unsigned DC_W = DIV_MAX;
      logic [DIVF_W-1:0] m_eff;
      logic [DC_W:0]     span;
      logic [DC_W-1:0]   lim;
      logic [DC_W-1:0]   dcnt;

      always_comb begin
         m_eff = (cfg.div_m > DIVF_W'(DIV_MAX)) ? DIVF_W'(DIV_MAX) : cfg.div_m;
         span  = (DC_W+1)'(1) << m_eff;
         lim   = DC_W'(span - 1'b1);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dcnt <= '0;
            tick <= 1'b0;
         end else if (strobe) begin
            if (dcnt >= lim) begin
               dcnt <= '0;
               tick <= 1'b1;
            end else begin
               dcnt <= dcnt + 1'b1;
               tick <= 1'b0;
            end
         end else begin
            tick <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pairpwm_chan.sv
module pairpwm_chan
   import pairpwm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             gate,
   input  logic             byp,
   input  chan_cfg_t        cfg,
   output logic             out,
   output logic             oe,
   output logic [CNT_W-1:0] pos,
   output logic             run
);

   logic [PRESC_W-1:0] pc;
   logic [CNT_W-1:0]   act_eff;
   logic               active;

   assign run     = en & gate;
   assign act_eff = (cfg.act > cfg.ent) ? cfg.ent : cfg.act;
   assign active  = pos < act_eff;
   assign oe      = en;

   always_comb begin
      if (!en)      out = 1'b0;
      else if (byp) out = tick;
      else          out = active ? cfg.pol : ~cfg.pol;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pc  <= '0;
         pos <= '0;
      end else if (pos > cfg.ent) begin
         pc  <= '0;
         pos <= '0;
      end else if (tick) begin
         if (pc >= cfg.presc) begin
            pc  <= '0;
            pos <= (pos >= cfg.ent) ? '0 : pos + 1'b1;
         end else begin
            pc <= pc + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pairpwm.sv
module pairpwm
   import pairpwm_pkg::*;
#(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DIV_MAX = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              bus_tick,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic [NUM_CH-1:0] pwm_out,
   output logic [NUM_CH-1:0] pwm_oe
);

   localparam int unsigned NPAIR = (NUM_CH + 1) / 2;

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("pairpwm: NUM_CH must lie in 1..16");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("pairpwm: ADDR_W must be at least 12");
   end
   if (DIV_MAX > 15) begin : g_bad_div
      $error("pairpwm: DIV_MAX must fit the 4-bit divider field");
   end

   pair_cfg_t [NPAIR-1:0]  pair_cfg;
   chan_cfg_t [NUM_CH-1:0] chan_cfg;
   logic [NUM_CH-1:0]      en_q, gate_q, byp_q;
   logic [NPAIR-1:0]       pair_tick;

   logic [NUM_CH-1:0][CNT_W-1:0] chan_pos;
   logic [NUM_CH-1:0][CNT_W-1:0] chan_ent;
   logic [NUM_CH-1:0]            chan_run;

   pairpwm_regs #(
      .NUM_CH (NUM_CH),
      .NPAIR  (NPAIR),
      .ADDR_W (ADDR_W)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pair_q    (pair_cfg),
      .chan_q    (chan_cfg),
      .en_q      (en_q),
      .gate_q    (gate_q),
      .byp_q     (byp_q)
   );

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      pairpwm_pairdiv #(
         .DIV_MAX (DIV_MAX)
      ) i_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .osc_tick (osc_tick),
         .bus_tick (bus_tick),
         .cfg      (pair_cfg[p]),
         .tick     (pair_tick[p])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      pairpwm_chan i_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (pair_tick[c/2]),
         .en    (en_q[c]),
         .gate  (gate_q[c]),
         .byp   (byp_q[c]),
         .cfg   (chan_cfg[c]),
         .out   (pwm_out[c]),
         .oe    (pwm_oe[c]),
         .pos   (chan_pos[c]),
         .run   (chan_run[c])
      );
      assign chan_ent[c] = chan_cfg[c].ent;
   end

endmodule

// File: rtl/pairpwm_chk.sv
module pairpwm_chk
   import pairpwm_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 12
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [ADDR_W-1:0]            reg_addr,
   input logic                         reg_we,
   input logic [NUM_CH-1:0]            en_wdata,
   input logic [BUS_W-1:0]             reg_rdata,
   input logic [NUM_CH-1:0]            pwm_out,
   input logic [NUM_CH-1:0]            pwm_oe,
   input logic [NUM_CH-1:0][CNT_W-1:0] chan_pos,
   input logic [NUM_CH-1:0][CNT_W-1:0] chan_ent,
   input logic [NUM_CH-1:0]            chan_run
);

   a_r4_oe_tracks_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(ENA_ADDR)) |=> (pwm_oe == $past(en_wdata)));

   a_r3_misaligned_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      a_r4_released_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
         !pwm_oe[c] |-> !pwm_out[c]);

      a_r12_shrink_restart: assert property (@(posedge clk) disable iff (!rst_n)
         (chan_pos[c] > chan_ent[c]) |=> (chan_pos[c] == '0));

      a_r10_halted_at_start: assert property (@(posedge clk) disable iff (!rst_n)
         !chan_run[c] |=> (chan_pos[c] == '0));
   end

endmodule

bind pairpwm pairpwm_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .en_wdata  (reg_wdata[NUM_CH-1:0]),
   .reg_rdata (reg_rdata),
   .pwm_out   (pwm_out),
   .pwm_oe    (pwm_oe),
   .chan_pos  (chan_pos),
   .chan_ent  (chan_ent),
   .chan_run  (chan_run)
);

// File: tb/test_pairpwm.sv
module test_pairpwm;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc_tick = 1'b1;
   logic        bus_tick = 1'b0;
   logic        bus_run = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NCH-1:0] pwm_out, pwm_oe;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) bus_tick <= bus_run ? ~bus_tick : 1'b0;

   pairpwm #(.NUM_CH(NCH), .ADDR_W(12), .DIV_MAX(8)) i_pairpwm (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_tick(bus_tick),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
   endtask

   task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic count_high(input int ch, input int win, output int hi);
      hi = 0;
      repeat (win) begin
         @(negedge clk);
         if (pwm_out[ch]) hi++;
      end
   endtask

   task automatic setup_ch(input int ch, input bit pol, input int k, input int ent, input int act);
      wr(12'h100 + 12'(ch*32), {23'd0, pol, 8'(k)});
      wr(12'h104 + 12'(ch*32), {16'(ent), 16'(act)});
   endtask

   task automatic quiesce();
      wr(12'h080, 32'h0);
      wr(12'h040, 32'h0);
      wr(12'h020, 32'h0);
      wr(12'h024, 32'h0);
      bus_run = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 oe after reset", pwm_oe, 0);
      rd_check("R1 pair0 cfg", 12'h020, 0);
      rd_check("R1 gate", 12'h040, 0);
      rd_check("R1 enable", 12'h080, 0);
      rd_check("R1 ch2 period", 12'h144, 0);
   endtask

   task automatic t_readback();
      wr(12'h020, 32'hFFFF_FFFF);
      rd_check("R2 pair0 masked", 12'h020, 32'h0000_018F);
      wr(12'h140, 32'hFFFF_FFFF);
      rd_check("R2 ch2 control masked", 12'h140, 32'h0000_01FF);
      wr(12'h124, 32'hDEAD_BEEF);
      rd_check("R2 ch1 period", 12'h124, 32'hDEAD_BEEF);
      wr(12'h040, 32'hFFFF_FFFF);
      rd_check("R2 gate and bypass", 12'h040, 32'h0007_0007);
      wr(12'h080, 32'hFFFF_FFFF);
      rd_check("R2 enable", 12'h080, 32'h0000_0007);
      quiesce();
      wr(12'h140, 0); wr(12'h124, 0);
   endtask

   task automatic t_unmapped();
      wr(12'h108, 32'hFFFF_FFFF);
      rd_check("R3 unmapped 0x108", 12'h108, 0);
      rd_check("R3 ch0 ctl untouched", 12'h100, 0);
      rd_check("R3 ch0 period untouched", 12'h104, 0);
      wr(12'h160, 32'h1FF);
      rd_check("R3 channel 3 out of range", 12'h160, 0);
      wr(12'h028, 32'h18F);
      rd_check("R3 pair 2 out of range", 12'h028, 0);
      rd_check("R3 pair 1 untouched", 12'h024, 0);
      wr(12'h101, 32'h1FF);
      rd_check("R3 misaligned read", 12'h101, 0);
      rd_check("R3 misaligned write ignored", 12'h100, 0);
   endtask

   task automatic t_enable();
      setup_ch(0, 1'b1, 0, 9, 3);
      wr(12'h040, 32'h1);
      wr(12'h080, 32'h1);
      @(negedge clk);
      check("R4 oe follows enable", pwm_oe, 3'b001);
      wr(12'h080, 32'h0);
      begin
         int hi;
         count_high(0, 30, hi);
         check("R4 disabled output low", hi, 0);
      end
      check("R4 oe dropped", pwm_oe, 0);
   endtask

   task automatic t_duty();
      int hi;
      setup_ch(0, 1'b1, 0, 9, 3);
      wr(12'h040, 32'h1); wr(12'h080, 32'h1);
      repeat (25) @(negedge clk);
      count_high(0, 100, hi);
      check("R5 duty 3 of 10 active high", hi, 30);
      setup_ch(0, 1'b0, 0, 9, 3);
      repeat (25) @(negedge clk);
      count_high(0, 100, hi);
      check("R5 duty active low", hi, 70);
   endtask

   task automatic t_clamp();
      int hi;
      setup_ch(0, 1'b1, 0, 4, 20);
      repeat (15) @(negedge clk);
      count_high(0, 50, hi);
      check("R6 active clamped to period field", hi, 40);
   endtask

   task automatic t_prescale();
      int hi;
      setup_ch(0, 1'b1, 2, 3, 1);
      repeat (30) @(negedge clk);
      count_high(0, 120, hi);
      check("R7 prescale k=2", hi, 30);
   endtask

   task automatic t_divider();
      int hi;
      setup_ch(0, 1'b1, 0, 1, 1);
      wr(12'h020, 32'h2);
      repeat (20) @(negedge clk);
      count_high(0, 80, hi);
      check("R8 div_m=2", hi, 40);
      wr(12'h020, 32'hC);
      repeat (1100) @(negedge clk);
      count_high(0, 1024, hi);
      check("R8 div_m=12 clamped to 8", hi, 512);
      wr(12'h020, 32'h0);
   endtask

   task automatic t_source();
      int hi;
      setup_ch(0, 1'b1, 0, 1, 1);
      setup_ch(1, 1'b1, 0, 3, 1);
      wr(12'h020, 32'h080);
      wr(12'h040, 32'h3); wr(12'h080, 32'h3);
      repeat (10) @(negedge clk);
      count_high(0, 40, hi);
      n_checks++;
      if (hi != 0 && hi != 40) begin
         n_fail++;
         $display("FAIL R9 bus source idle: actual %0d expected 0 or 40", hi);
      end
      bus_run = 1'b1;
      repeat (20) @(negedge clk);
      count_high(0, 40, hi);
      check("R9 bus source ch0", hi, 20);
      count_high(1, 40, hi);
      check("R9 sibling shares bus source", hi, 10);
      quiesce();
   endtask

   task automatic t_gate();
      int hi;
      setup_ch(0, 1'b1, 0, 9, 3);
      wr(12'h040, 32'h0); wr(12'h080, 32'h1);
      repeat (5) @(negedge clk);
      count_high(0, 50, hi);
      check("R10 ungated held at tick 0", hi, 50);
      wr(12'h040, 32'h1);
      repeat (25) @(negedge clk);
      count_high(0, 50, hi);
      check("R10 gated counting", hi, 15);
      quiesce();
   endtask

   task automatic t_bypass();
      int hi;
      setup_ch(2, 1'b1, 0, 9, 3);
      wr(12'h024, 32'h1);
      wr(12'h040, 32'h0001_0000 << 2);
      wr(12'h080, 32'h4);
      repeat (5) @(negedge clk);
      count_high(2, 50, hi);
      check("R11 bypass follows divided pulse", hi, 25);
      quiesce();
   endtask

   task automatic t_midperiod();
      int guard;
      setup_ch(0, 1'b1, 0, 199, 100);
      wr(12'h040, 32'h1); wr(12'h080, 32'h1);
      guard = 0;
      @(negedge clk);
      while (pwm_out[0] && guard < 300) begin
         @(negedge clk);
         guard++;
      end
      repeat (20) @(negedge clk);
      check("R12 low phase before rewrite", pwm_out[0], 0);
      wr(12'h104, {16'd9, 16'd5});
      @(negedge clk);
      check("R12 restart without waiting for boundary", pwm_out[0], 1);
      quiesce();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_unmapped();
      t_enable();
      t_duty();
      t_clamp();
      t_prescale();
      t_divider();
      quiesce();
      t_source();
      t_gate();
      t_bypass();
      t_midperiod();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule